// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block listens to the serial data-link bits that the framer pulls out of the framing-bit positions of an extended-superframe line, one bit per `dl_valid` strobe. It finds 16-bit repeating messages: a flag of eight ones, a zero, a six-bit code and a closing zero. Codes that keep repeating go to a persistence vote. Once a code has enough votes and differs from the code the block last reported, it is latched and a sticky indication is raised.

The vote has two rules, chosen by `vote_long`. The short rule needs the code in 4 of the last 5 received messages. The long rule needs it in 8 of the last 10. The indication stays set until software writes a one to `ind_clr`. `irq` is the indication gated by `irq_en`.

Top module: `bom_receiver`

## Requirements
- R1: When `esf_mode` is 0, incoming bits are ignored. They do not advance alignment, they add nothing to the vote history, and they do not change the outputs.
- R2: A message is the arrival sequence 1,1,1,1,1,1,1,1,0,c5,c4,c3,c2,c1,c0,0. The first code bit to arrive becomes bit 5 of `msg_code`.
- R3: With `vote_long`=0, a code qualifies when it appears in at least 4 of the last 5 recognised messages. With `vote_long`=1, it qualifies when it appears in at least 8 of the last 10. The newest message's code is the one voted on.
- R4: A qualified code is declared only if it differs from the last declared code. After reset the last declared code is 6'b000000.
- R5: On a declaration, `msg_code` takes the code on the second rising edge after the edge that sampled the message's final bit.
- R6: Every update of `msg_code` sets `msg_ind`, and `msg_ind` then stays set.
- R7: `ind_clr`=1 clears `msg_ind`. If an update happens in the same cycle, `msg_ind` ends up set.
- R8: `irq` is 1 exactly when `msg_ind` is 1 and `irq_en` is 1.
- R9: A 16-bit group that fails the pattern while aligned drops alignment and is not counted. The receiver then searches bit by bit and recognises the next good message at its last bit.
- R10: Reset clears `msg_code`, `msg_ind`, the vote history and the last declared code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_bit | input | 1 | Data-link bit |
| dl_valid | input | 1 | Qualifies `dl_bit` for one cycle |
| esf_mode | input | 1 | 1 when the line uses extended-superframe framing |
| vote_long | input | 1 | 0: 4-of-5 rule, 1: 8-of-10 rule |
| irq_en | input | 1 | Interrupt enable |
| ind_clr | input | 1 | Write-one clear of the indication |
| msg_code | output | 6 | Last declared message code |
| msg_ind | output | 1 | Sticky update indication |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to create is a clear that arrives in the same cycle as an update. The update lands two edges after the final bit of a message, so there is only one cycle in which the two can meet. The bench holds `ind_clr` high from before the declaring message starts until just after that edge, which guarantees the two coincide. A second hard case is loss of alignment in the middle of a run. A group with a bad closing bit is placed between good ones, and the bench expects the vote to lag by exactly one message.

// File: rtl/bomr_pkg.sv
package bomr_pkg;
  localparam int CODE_W    = 6;
  localparam int FLAG_ONES = 8;
  localparam int FRAME_W   = FLAG_ONES + CODE_W + 2;

  typedef logic [CODE_W-1:0] code_t;

  // oldest bit at the MSB: flag ones, zero, code, zero
  function automatic logic frame_ok(input logic [FRAME_W-1:0] f);
    return (f[FRAME_W-1 -: FLAG_ONES] == {FLAG_ONES{1'b1}}) &&
           !f[CODE_W+1] && !f[0];
  endfunction

  function automatic code_t frame_code(input logic [FRAME_W-1:0] f);
    return f[CODE_W:1];
  endfunction

  function automatic int vote_window(input logic long_rule, input int win_s, input int win_l);
    return long_rule ? win_l : win_s;
  endfunction

  function automatic int vote_threshold(input logic long_rule, input int thr_s, input int thr_l);
    return long_rule ? thr_l : thr_s;
  endfunction
endpackage

// File: rtl/bomr_align.sv
module bomr_align
  import bomr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dl_bit,
  input  logic  dl_valid,
  input  logic  esf_mode,
  output logic  frame_evt,
  output code_t frame_cd
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-2:0] sr_q;
  logic [FRAME_W-1:0] sr_nxt;
  logic               hunt_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               shift, pat_ok, at_edge, take, lose;

  assign shift   = dl_valid & esf_mode;
  assign sr_nxt  = {sr_q, dl_bit};
  assign pat_ok  = frame_ok(sr_nxt);
  assign at_edge = hunt_q | (cnt_q == LAST);
  assign take    = shift & at_edge & pat_ok;
  assign lose    = shift & !hunt_q & (cnt_q == LAST) & !pat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      hunt_q    <= 1'b1;
      cnt_q     <= '0;
      frame_evt <= 1'b0;
      frame_cd  <= '0;
    end else begin
      frame_evt <= take;
      if (take)  frame_cd <= frame_code(sr_nxt);
      if (shift) sr_q <= sr_nxt[FRAME_W-2:0];
      if (take) begin
        hunt_q <= 1'b0;
        cnt_q  <= '0;
      end else if (lose) begin
        hunt_q <= 1'b1;
      end else if (shift && !hunt_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> !frame_evt); // R1
  AST_LOSS_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> !frame_evt); // R9
endmodule

// File: rtl/bomr_vote.sv
module bomr_vote
  import bomr_pkg::*;
#(
  parameter int HIST  = 10,
  parameter int WIN_S = 5,
  parameter int THR_S = 4,
  parameter int WIN_L = 10,
  parameter int THR_L = 8
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_evt,
  input  code_t frame_cd,
  input  logic  vote_long,
  output logic  qual_evt,
  output code_t qual_code
);
  localparam int CNT_W = $clog2(HIST + 1);

  code_t            hist_q [HIST];
  logic [CNT_W-1:0] fill_q;
  logic             pend_q;
  logic [HIST-1:0]  hit;
  logic [CNT_W-1:0] win_c, thr_c, hits_c;

  assign win_c  = CNT_W'(vote_window(vote_long, WIN_S, WIN_L));
  assign thr_c  = CNT_W'(vote_threshold(vote_long, THR_S, THR_L));
  assign hits_c = CNT_W'($countones(hit));

  generate
    for (genvar i = 0; i < HIST; i++) begin : g_hit
      assign hit[i] = (CNT_W'(i) < fill_q) && (CNT_W'(i) < win_c) &&
                      (hist_q[i] == hist_q[0]);
    end
  endgenerate

  assign qual_evt  = pend_q && (hits_c >= thr_c);
  assign qual_code = hist_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
      fill_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= frame_evt;
      if (frame_evt) begin
        hist_q[0] <= frame_cd;
        for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
        if (fill_q < CNT_W'(HIST)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  AST_QUAL_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |-> $past(frame_evt)); // R3
  AST_QUAL_HAS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |-> (fill_q >= CNT_W'(vote_long ? THR_L : THR_S))); // R3
endmodule

// File: rtl/bom_receiver.sv
module bom_receiver
  import bomr_pkg::*;
#(
  parameter int HIST  = 10,
  parameter int WIN_S = 5,
  parameter int THR_S = 4,
  parameter int WIN_L = 10,
  parameter int THR_L = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_bit,
  input  logic              dl_valid,
  input  logic              esf_mode,
  input  logic              vote_long,
  input  logic              irq_en,
  input  logic              ind_clr,
  output logic [CODE_W-1:0] msg_code,
  output logic              msg_ind,
  output logic              irq
);
  logic  frame_evt, qual_evt, upd_evt;
  code_t frame_cd, qual_code, code_q;
  logic  ind_q;

  bomr_align u_align (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
    .esf_mode(esf_mode), .frame_evt(frame_evt), .frame_cd(frame_cd)
  );

  bomr_vote #(.HIST(HIST), .WIN_S(WIN_S), .THR_S(THR_S), .WIN_L(WIN_L), .THR_L(THR_L)) u_vote (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .frame_cd(frame_cd),
    .vote_long(vote_long), .qual_evt(qual_evt), .qual_code(qual_code)
  );

  // the latched code doubles as the last-declared code
  assign upd_evt = qual_evt && (qual_code != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ind_q  <= 1'b0;
    end else begin
      if (upd_evt) code_q <= qual_code;
      if (upd_evt)      ind_q <= 1'b1;
      else if (ind_clr) ind_q <= 1'b0;
    end
  end

  assign msg_code = code_q;
  assign msg_ind  = ind_q;
  assign irq      = ind_q & irq_en;

  AST_UPD_NEW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (msg_code != $past(msg_code))); // R4
  AST_CODE_MOVE_SETS_IND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg_code) |-> msg_ind); // R6
  AST_IND_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_ind) |-> $past(ind_clr)); // R7
  AST_IRQ_NEEDS_IND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msg_ind && irq_en)); // R8
endmodule

// File: tb/bom_receiver_test.sv
module bom_receiver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dl_bit = 1'b0, dl_valid = 1'b0, esf_mode = 1'b1, vote_long = 1'b0;
  logic       irq_en = 1'b0, ind_clr = 1'b0;
  logic [5:0] msg_code;
  logic       msg_ind, irq;

  int n_checks = 0, n_fail = 0;
  int hist[$];
  logic [5:0] last_decl = 6'd0;
  logic [5:0] exp_q[$];

  always #2 clk = ~clk;

  bom_receiver uut (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
    .esf_mode(esf_mode), .vote_long(vote_long), .irq_en(irq_en), .ind_clr(ind_clr),
    .msg_code(msg_code), .msg_ind(msg_ind), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: updates the model, pushes the expected declaration, then sends the bits
  task automatic send_msg(input logic [5:0] code, input bit broken);
    logic [15:0] frame;
    if (!broken && esf_mode) begin
      int win, thr, n;
      hist.push_front(code);
      if (hist.size() > 10) void'(hist.pop_back());
      win = vote_long ? 10 : 5;
      thr = vote_long ? 8 : 4;
      n = 0;
      for (int i = 0; i < win && i < hist.size(); i++) if (hist[i] == code) n++;
      if (n >= thr && code != last_decl) begin
        last_decl = code;
        exp_q.push_back(code);
      end
    end
    frame = {8'hFF, 1'b0, code, broken};
    for (int b = 15; b >= 0; b--) begin
      @(negedge clk);
      dl_bit = frame[b];
      dl_valid = 1'b1;
    end
    @(negedge clk); dl_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 code after message", msg_code, last_decl);
  endtask

  task automatic send_n(input logic [5:0] code, input int n);
    for (int k = 0; k < n; k++) send_msg(code, 1'b0);
  endtask

  // monitor: every move of msg_code must match the next expected item
  initial begin
    logic [5:0] prev = 6'd0;
    forever begin
      @(negedge clk);
      if (!rst_n) prev = msg_code;
      else if (msg_code !== prev) begin
        if (exp_q.size() == 0) check("R4 unexpected update", msg_code, prev);
        else check("R5 scoreboard", msg_code, exp_q.pop_front());
        check("R6 ind with update", msg_ind, 1);
        prev = msg_code;
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    hist.delete(); last_decl = 6'd0; exp_q.delete();
    repeat (3) @(negedge clk);
    check("R10 code reset", msg_code, 0);
    check("R10 ind reset", msg_ind, 0);
    check("R8 irq reset", irq, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R4: code zero equals the reset last-declared code
    send_n(6'h00, 4);
    check("R4 zero not declared", msg_ind, 0);
    // R2 / R3 short rule, asymmetric code catches bit order
    send_n(6'h20, 3);
    check("R3 three of five not enough", msg_ind, 0);
    send_msg(6'h20, 1'b0);
    check("R2 code bit order", msg_code, 6'h20);
    check("R8 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R8 irq enabled", irq, 1);
    // R7 plain clear
    ind_clr = 1'b1; @(negedge clk); ind_clr = 1'b0; @(negedge clk);
    check("R7 clear", msg_ind, 0);
    check("R8 irq follows clear", irq, 0);
    // R4 repeated code not redeclared
    send_n(6'h20, 2);
    check("R4 same code no update", msg_ind, 0);
    // R3 non-consecutive 4 of 5
    send_msg(6'h01, 1'b0); send_msg(6'h01, 1'b0); send_msg(6'h15, 1'b0);
    send_msg(6'h01, 1'b0); send_msg(6'h01, 1'b0);
    check("R3 interleaved vote", msg_code, 6'h01);
    // R1 non-ESF stream ignored
    esf_mode = 1'b0;
    send_n(6'h2A, 5);
    check("R1 ignored outside ESF", msg_code, 6'h01);
    esf_mode = 1'b1;
    // R3 long rule
    vote_long = 1'b1;
    send_n(6'h0C, 7);
    check("R3 seven of ten not enough", msg_code, 6'h01);
    send_msg(6'h0C, 1'b0);
    check("R3 eight of ten", msg_code, 6'h0C);
    vote_long = 1'b0;
    // R9 broken group not counted, realignment
    send_msg(6'h33, 1'b0); send_msg(6'h33, 1'b0);
    send_msg(6'h33, 1'b1);
    send_msg(6'h33, 1'b0);
    check("R9 broken group not counted", msg_code, 6'h0C);
    send_msg(6'h33, 1'b0);
    check("R9 realigned", msg_code, 6'h33);
    // R7 clear and set in the same cycle
    ind_clr = 1'b1; @(negedge clk); ind_clr = 1'b0; @(negedge clk);
    send_n(6'h2D, 3);
    ind_clr = 1'b1;
    send_msg(6'h2D, 1'b0);
    ind_clr = 1'b0;
    check("R7 set wins over clear", msg_ind, 1);
    // R10 history and last code cleared by reset
    do_reset();
    send_n(6'h2D, 3);
    check("R10 history cleared", msg_ind, 0);
    send_msg(6'h2D, 1'b0);
    check("R10 last code cleared", msg_code, 6'h2D);
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule